// File: doc/BRIEF.md
# System Control Output Port

This block holds the 8-bit system control register that a keyboard-style host controller exposes as its output port. Bit 1 of the register gates address line 20, and bit 0 is the run/reset bit: writing it as 0 asks the system to reset. The register can be written from two host paths, a dedicated fast control port and the controller's own write-output-port data path. It is also changed by two controller commands that set or clear the A20 bit, and by a family of pulse commands that can request a reset without changing the stored value.

The block drives a level output for the A20 gate and a reset request pulse. The pulse width is a parameter in clock cycles. Its default of 1200 cycles gives about 6 microseconds at a 200 MHz clock. A read returns the stored byte, except that bits 4 and 5 show the controller's keyboard-buffer-full and auxiliary-buffer-full flags.

Top module: `sys_outport`

## Requirements
- R1: After reset, bits 0 and 1 of the stored register are 1 and all other stored bits are 0 (read value 0x03 with both full flags low), `a20En` is 1 and `resetReq` is 0.
- R2: A write on either write path stores the whole byte, which is visible on `rdData` in the next cycle. `a20En` then equals bit 1 of the written byte.
- R3: A write whose bit 0 is 0 makes `resetReq` high for exactly `PULSE_CYCLES` cycles, starting in the cycle after the write.
- R4: Command 0xDF sets stored bit 1 and command 0xDD clears it. Both take effect in the next cycle, leave the other bits unchanged, and `a20En` follows.
- R5: A command whose upper four bits are 1111 is a pulse command. If its bit 0 is 0, it starts a reset pulse as in R3 and leaves the register unchanged. If its bit 0 is 1, it has no effect.
- R6: When both write paths write in the same cycle, the fast-port byte is stored and the other byte is discarded.
- R7: When a write and an A20 command arrive in the same cycle, the written byte is stored and the command is ignored.
- R8: `rdData` bit 4 equals `kbdFull` and bit 5 equals `auxFull` in the same cycle. The other six bits come from the stored register.
- R9: A new reset trigger during a running pulse restarts the pulse, so it stays high for `PULSE_CYCLES` cycles after the last trigger.
- R10: Any command code other than 0xDF, 0xDD or a pulse command changes neither the register nor `resetReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fastWrEn | input | 1 | Write strobe from the fast control port |
| fastWrData | input | 8 | Byte written by the fast control port |
| ctlWrEn | input | 1 | Write strobe from the controller's write-output-port path |
| ctlWrData | input | 8 | Byte written by the controller path |
| cmdValid | input | 1 | A controller command byte is present |
| cmdCode | input | 8 | Controller command byte |
| kbdFull | input | 1 | Keyboard output-buffer-full flag, shown on read bit 4 |
| auxFull | input | 1 | Auxiliary output-buffer-full flag, shown on read bit 5 |
| rdData | output | 8 | Read value of the register with the full flags inserted |
| a20En | output | 1 | Address-line-20 enable level |
| resetReq | output | 1 | System reset request pulse |

## Verification
Some properties are checked on every cycle. `a20En` follows the bit 1 of each stored write and each set or clear command. The reset request is high exactly in the window of `PULSE_CYCLES` cycles after the latest trigger, and never before the first trigger. At most one A20 action is decoded per cycle, and a pulse command with bit 0 set raises no trigger. Other behaviours are shown only by the bench's scenarios, which compare against its behavioural model on every clock. These include: which path wins when writes and commands collide, that non-A20 bits survive the A20 commands, the live mirroring of the full flags on read, and that unrelated command codes leave the port untouched.

// File: rtl/outport_pkg.sv
package outport_pkg;
  localparam int unsigned BYTE_W = 8;

  // Strobes from the decode/control side to the register datapath.
  typedef struct packed {
    logic              store;   // replace the whole register
    logic [BYTE_W-1:0] data;    // byte to store
    logic              setA20;  // set bit 1
    logic              clrA20;  // clear bit 1
    logic              trig;    // (re)start the reset pulse
  } portStrobe_t;
endpackage

// File: rtl/outport_ctrl.sv
module outport_ctrl
  import outport_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              fastWrEn,
  input  logic [BYTE_W-1:0] fastWrData,
  input  logic              ctlWrEn,
  input  logic [BYTE_W-1:0] ctlWrData,
  input  logic              cmdValid,
  input  logic [BYTE_W-1:0] cmdCode,
  output portStrobe_t       strobe
);
  localparam logic [BYTE_W-1:0] CMD_A20_ON  = 8'hDF;
  localparam logic [BYTE_W-1:0] CMD_A20_OFF = 8'hDD;
  localparam logic [3:0]        PULSE_NIB   = 4'hF;

  logic              anyWrite;
  logic [BYTE_W-1:0] wrByte;
  logic              isPulseCmd;
  logic              pulseReset;

  always_comb begin
    anyWrite   = fastWrEn | ctlWrEn;
    // fast port has precedence over the controller path
    wrByte     = fastWrEn ? fastWrData : ctlWrData;
    isPulseCmd = cmdValid && (cmdCode[7:4] == PULSE_NIB);
    pulseReset = isPulseCmd && !cmdCode[0];

    strobe.store  = anyWrite;
    strobe.data   = wrByte;
    strobe.setA20 = !anyWrite && cmdValid && (cmdCode == CMD_A20_ON);
    strobe.clrA20 = !anyWrite && cmdValid && (cmdCode == CMD_A20_OFF);
    strobe.trig   = (anyWrite && !wrByte[0]) || pulseReset;
  end

  AST_ONE_A20_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.setA20, strobe.clrA20, strobe.store})); // R7

  AST_NOP_PULSE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode[7:4] == PULSE_NIB && cmdCode[0] && !fastWrEn && !ctlWrEn)
      |-> !strobe.trig); // R5
endmodule

// File: rtl/outport_dp.sv
module outport_dp
  import outport_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = 1200
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrobe_t       strobe,
  input  logic              kbdFull,
  input  logic              auxFull,
  output logic [BYTE_W-1:0] rdData,
  output logic              a20En,
  output logic              resetReq
);
  localparam int unsigned CNT_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYCLES);
  localparam logic [BYTE_W-1:0] RST_VAL = 8'h03;

  logic [BYTE_W-1:0] portReg;
  logic [CNT_W-1:0]  pulseCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                portReg    <= RST_VAL;
    else if (strobe.store)    portReg    <= strobe.data;
    else if (strobe.setA20)   portReg[1] <= 1'b1;
    else if (strobe.clrA20)   portReg[1] <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                pulseCnt <= '0;
    else if (strobe.trig)     pulseCnt <= CNT_LOAD;
    else if (pulseCnt != '0)  pulseCnt <= pulseCnt - 1'b1;
  end

  assign a20En    = portReg[1];
  assign resetReq = (pulseCnt != '0);
  assign rdData   = {portReg[7:6], auxFull, kbdFull, portReg[3:0]};

  // Checker state: cycles elapsed since the most recent trigger.
  logic [CNT_W-1:0] sinceTrig;
  logic             seenTrig;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceTrig <= '0;
      seenTrig  <= 1'b0;
    end else if (strobe.trig) begin
      sinceTrig <= '0;
      seenTrig  <= 1'b1;
    end else if (sinceTrig != CNT_LOAD) begin
      sinceTrig <= sinceTrig + 1'b1;
    end
  end

  AST_A20_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.store |=> (a20En == $past(strobe.data[1]))); // R2

  AST_A20_SET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setA20 |=> a20En); // R4

  AST_A20_CLR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrA20 |=> !a20En); // R4

  AST_NO_SPURIOUS_RESET: assert property (@(posedge clk) disable iff (!rstN)
    !seenTrig |-> !resetReq); // R3

  AST_PULSE_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    seenTrig |-> (resetReq == (sinceTrig < CNT_LOAD))); // R9
endmodule

// File: rtl/sys_outport.sv
module sys_outport
  import outport_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = 1200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       fastWrEn,
  input  logic [7:0] fastWrData,
  input  logic       ctlWrEn,
  input  logic [7:0] ctlWrData,
  input  logic       cmdValid,
  input  logic [7:0] cmdCode,
  input  logic       kbdFull,
  input  logic       auxFull,
  output logic [7:0] rdData,
  output logic       a20En,
  output logic       resetReq
);
  portStrobe_t strobe;

  outport_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .fastWrEn   (fastWrEn),
    .fastWrData (fastWrData),
    .ctlWrEn    (ctlWrEn),
    .ctlWrData  (ctlWrData),
    .cmdValid   (cmdValid),
    .cmdCode    (cmdCode),
    .strobe     (strobe)
  );

  outport_dp #(.PULSE_CYCLES(PULSE_CYCLES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .kbdFull  (kbdFull),
    .auxFull  (auxFull),
    .rdData   (rdData),
    .a20En    (a20En),
    .resetReq (resetReq)
  );
endmodule

// File: tb/sys_outport_tb.sv
module sys_outport_tb;
  localparam int PW = 1200;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fastWrEn = 1'b0, ctlWrEn = 1'b0, cmdValid = 1'b0;
  logic [7:0] fastWrData = 8'h00, ctlWrData = 8'h00, cmdCode = 8'h00;
  logic       kbdFull = 1'b0, auxFull = 1'b0;
  logic [7:0] rdData;
  logic       a20En, resetReq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sys_outport #(.PULSE_CYCLES(PW)) u_dut (
    .clk(clk), .rstN(rstN),
    .fastWrEn(fastWrEn), .fastWrData(fastWrData),
    .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .cmdValid(cmdValid), .cmdCode(cmdCode),
    .kbdFull(kbdFull), .auxFull(auxFull),
    .rdData(rdData), .a20En(a20En), .resetReq(resetReq)
  );

  // Behavioural reference model
  int mReg = 3;
  int mRem = 0;
  always @(posedge clk) begin
    if (!rstN) begin
      mReg = 3; mRem = 0;
    end else begin
      int wb;
      bit wr, trig;
      wr = fastWrEn || ctlWrEn;
      wb = fastWrEn ? int'(fastWrData) : int'(ctlWrData);
      trig = 0;
      if (wr) begin
        mReg = wb;
        if ((wb % 2) == 0) trig = 1;
      end else if (cmdValid && cmdCode == 8'hDF) mReg = mReg | 2;
      else if (cmdValid && cmdCode == 8'hDD) mReg = mReg & ~2;
      if (cmdValid && cmdCode >= 8'hF0 && (cmdCode % 2) == 0) trig = 1;
      if (trig) mRem = PW;
      else if (mRem > 0) mRem = mRem - 1;
    end
  end

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    int expRd;
    expRd = (mReg & 8'hCF) | (int'(auxFull) << 5) | (int'(kbdFull) << 4);
    check(int'(rdData), expRd, "R8 rdData vs model");
    check(int'(a20En), (mReg >> 1) & 1, "R2 a20En vs model");
    check(int'(resetReq), (mRem > 0) ? 1 : 0, "R3 resetReq vs model");
  endtask

  task automatic cycle();
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle();
    fastWrEn = 0; ctlWrEn = 0; cmdValid = 0;
  endtask

  task automatic idleN(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic fastWr(input logic [7:0] b);
    fastWrEn = 1; fastWrData = b; cycle(); idle();
  endtask

  task automatic ctlWr(input logic [7:0] b);
    ctlWrEn = 1; ctlWrData = b; cycle(); idle();
  endtask

  task automatic cmd(input logic [7:0] c);
    cmdValid = 1; cmdCode = c; cycle(); idle();
  endtask

  initial begin
    #(5 * 190000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int hiCount;
    repeat (3) @(negedge clk);
    rstN = 1;
    cycle();
    // R1: reset state
    check(int'(rdData), 8'h03, "R1 reset read value");
    check(int'(a20En), 1, "R1 reset a20En");
    check(int'(resetReq), 0, "R1 reset resetReq");

    // R8: live mirror bits
    kbdFull = 1; cycle();
    check(int'(rdData), 8'h13, "R8 kbdFull on bit4");
    auxFull = 1; kbdFull = 0; cycle();
    check(int'(rdData), 8'h23, "R8 auxFull on bit5");
    auxFull = 0;

    // R2: writes on both paths, bits 4/5 of stored byte hidden on read
    fastWr(8'hC9);
    check(int'(rdData), 8'hC9, "R2 fast write stored");
    check(int'(a20En), 0, "R2 a20 low after fast write");
    ctlWr(8'h3B);
    check(int'(rdData), 8'h0B, "R2 ctl write stored, bits 4/5 hidden R8");
    check(int'(a20En), 1, "R2 a20 high after ctl write");

    // R4: A20 commands keep other bits
    cmd(8'hDD);
    check(int'(rdData), 8'h09, "R4 clear A20");
    cmd(8'hDF);
    check(int'(rdData), 8'h0B, "R4 set A20");

    // R10: unrelated commands have no effect
    cmd(8'hAA); cmd(8'hD1); cmd(8'h20);
    check(int'(rdData), 8'h0B, "R10 other commands ignored");
    check(int'(resetReq), 0, "R10 no reset from other commands");

    // R5: pulse command with bit0=1 is a no-op
    cmd(8'hFF); cmd(8'hF7);
    check(int'(resetReq), 0, "R5 odd pulse command is no-op");

    // R6: both write paths at once
    fastWrEn = 1; fastWrData = 8'h47; ctlWrEn = 1; ctlWrData = 8'h81;
    cycle(); idle();
    check(int'(rdData), 8'h47, "R6 fast port wins");

    // R7: write with A20 command in the same cycle
    ctlWrEn = 1; ctlWrData = 8'h05; cmdValid = 1; cmdCode = 8'hDF;
    cycle(); idle();
    check(int'(rdData), 8'h05, "R7 write beats A20 command");
    check(int'(a20En), 0, "R7 a20 follows write");

    // R3: write with bit0 = 0 -> pulse of PW cycles
    hiCount = 0;
    fastWr(8'h02);
    check(int'(resetReq), 1, "R3 pulse starts after write");
    hiCount = 1;
    for (int i = 0; i < PW + 4; i++) begin
      cycle();
      if (resetReq) hiCount++;
    end
    check(hiCount, PW, "R3 pulse width");

    // R5: pulse command 0xFE triggers reset, register unchanged
    fastWr(8'h03);
    cmd(8'hFE);
    check(int'(resetReq), 1, "R5 0xFE triggers reset");
    check(int'(rdData), 8'h03, "R5 register unchanged by pulse command");
    idleN(PW + 2);
    cmd(8'hF0);
    check(int'(resetReq), 1, "R5 0xF0 triggers reset");

    // R9: retrigger halfway restarts the full width
    idleN(PW / 2);
    hiCount = 0;
    cmd(8'hFA);
    hiCount = 1;
    for (int i = 0; i < PW + 4; i++) begin
      cycle();
      if (resetReq) hiCount++;
    end
    check(hiCount, PW, "R9 retrigger restarts pulse");

    idleN(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule